// File: doc/BRIEF.md
# Wide Register Bus Collector

This unit sits behind a narrow memory-mapped slave port (32-bit or 64-bit beats) and in front of a bank of 128-bit control registers, 64-bit buffer-table entries and 32-bit doorbells. Software can only reach a wide register in pieces. The unit gathers those pieces in a holding register and updates the target in one step, when the highest word arrives, so the register never shows a half-written value. Reads work the other way round. Fetching the lowest word of a 128-bit register freezes the whole register into a read shadow, and the remaining words come from that frozen copy.

Three doorbell registers per page take a single 32-bit write straight away and never touch the holding register. A driver can therefore ring a doorbell while another context is partway through a wide update. The address space is split into equal per-queue pages. Each page holds a small table of wide registers and the doorbells. The buffer-table entries sit at a separate base address. The bank inside the block keeps every register, so all state can be read back through the same port.

Top module: `wide_reg_collector`

## Requirements
- R1: After reset, `rd_valid`, `commit_stb` and `seq_err` are low, and every register, buffer entry and doorbell reads as zero.
- R2: A wide register written as 32-bit words at +0, +4 and +8 keeps its old value until the word at +12 is written. That write then updates all 128 bits at once. A 32-bit word at +k lands in bits [8k+31:8k], little-endian.
- R3: A wide register can also be written as two 64-bit beats at +0 and +8, and 32-bit and 64-bit beats may be mixed. The commit happens on the beat that carries the +12 word.
- R4: A buffer entry written as two 32-bit words commits when the word at +4 arrives. A single 64-bit write at +0 commits at once and leaves any pending collection untouched.
- R5: A read of +0 of a wide register (32-bit or 64-bit) returns live data and captures all 128 bits into one shared shadow. Reads at +4, +8 and +12, or a 64-bit read at +8, return the shadow even if the register has changed since.
- R6: The doorbells sit at page offsets 0x100, 0x110 and 0x120. A 32-bit doorbell write takes effect on the next edge. A doorbell write made during a wide collection neither commits nor alters that collection.
- R7: Page p starts at p*0x2000, and wide register n of that page sits at p*0x2000 + n*16. Its commit index is p*NUM_WIDE + n. Buffer entry i sits at SRAM_BASE + i*8 and has commit index i. Doorbell k of page p has index p*3 + k.
- R8: A write to a non-top word of a different wide register or buffer entry drops the held words and restarts collection. Words that are not written during the collection commit as zero.
- R9: A top-word write to a target other than the pending one, or with nothing pending, is ignored. It sets the sticky `seq_err`, which only reset clears, and the pending collection is kept.
- R10: Every read gives `rd_valid` for exactly the following cycle. A 32-bit read returns its word in `rd_data[31:0]` with the upper half zero. Unmapped reads return zero. Misaligned addresses, 64-bit accesses at an odd word and 64-bit doorbell accesses are ignored.
- R11: Each commit pulses `commit_stb` in the cycle after the committing beat, together with `commit_sram`, `commit_idx` and the full `commit_data`. Buffer data is placed in bits [63:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Request present; one is accepted every cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_wide | input | 1 | 1 = 64-bit beat, 0 = 32-bit beat |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 64 | Write data; 32-bit beats use [31:0] |
| rd_valid | output | 1 | Read data valid, one cycle after the read |
| rd_data | output | 64 | Read data |
| commit_stb | output | 1 | One-cycle commit pulse |
| commit_sram | output | 1 | Commit targets a buffer entry |
| commit_idx | output | IDX_W | Index of the committed register or entry |
| commit_data | output | 128 | Committed value |
| seq_err | output | 1 | Sticky collection-order error |

## Verification
The risky case is a doorbell write landing between the partial words of a wide collection. The collector must then stay untouched while the doorbell register changes on that same edge. The bench sets this up on purpose by starting a collection, ringing a doorbell and then sending the top word, and the random phase interleaves the two freely. Each time, the bench compares the commit pulse, the committed value and a read-back of the doorbell against its own model. A second case checks that a read of +0 issued right after a committing top word snapshots the new value and not the old one.

// File: rtl/wrc_pkg.sv
package wrc_pkg;
  parameter int IDX_W = 6;
  localparam int NUM_DB = 3;

  typedef enum logic [1:0] {
    K_NONE = 2'd0,
    K_WIDE = 2'd1,
    K_SRAM = 2'd2,
    K_DB   = 2'd3
  } kind_e;

  typedef struct packed {
    kind_e            kind;
    logic [IDX_W-1:0] idx;
    logic [1:0]       word;
  } tgt_t;
endpackage

// File: rtl/wrc_decode.sv
module wrc_decode
  import wrc_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int NUM_PAGES  = 2,
  parameter int NUM_WIDE   = 4,
  parameter int NUM_SRAM   = 8,
  parameter int PAGE_BYTES = 8192,
  parameter int SRAM_BASE  = 'h10000,
  parameter int DB_BASE    = 'h100
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wide,
  output tgt_t              tgt
);
  localparam int PAGE_SHIFT = $clog2(PAGE_BYTES);

  always_comb begin
    logic [ADDR_W-1:0] sofs;
    int page;
    int pofs;
    tgt  = '0;
    sofs = addr - ADDR_W'(SRAM_BASE);
    page = int'(addr >> PAGE_SHIFT);
    pofs = int'(addr[PAGE_SHIFT-1:0]);
    if (addr[1:0] == 2'b00 && !(wide && addr[2])) begin
      if (addr >= ADDR_W'(SRAM_BASE) && sofs < ADDR_W'(NUM_SRAM * 8)) begin
        tgt.kind = K_SRAM;
        tgt.idx  = IDX_W'(sofs >> 3);
        tgt.word = {1'b0, sofs[2]};
      end else if (page < NUM_PAGES) begin
        if (pofs < NUM_WIDE * 16) begin
          tgt.kind = K_WIDE;
          tgt.idx  = IDX_W'(page * NUM_WIDE + pofs / 16);
          tgt.word = addr[3:2];
        end else if (!wide && addr[3:2] == 2'b00 && pofs >= DB_BASE &&
                     pofs < DB_BASE + NUM_DB * 16) begin
          tgt.kind = K_DB;
          tgt.idx  = IDX_W'(page * NUM_DB + (pofs - DB_BASE) / 16);
        end
      end
    end
  end
endmodule

// File: rtl/wrc_collector.sv
module wrc_collector
  import wrc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_wr,
  input  logic             wide,
  input  tgt_t             tgt,
  input  logic [63:0]      wdata,
  output logic             cmt_en,
  output logic [127:0]     cmt_data,
  output logic             commit_stb,
  output logic             commit_sram,
  output logic [IDX_W-1:0] commit_idx,
  output logic [127:0]     commit_data,
  output logic             seq_err
);
  logic             pend_v_q, pend_v_d;
  kind_e            pend_k_q, pend_k_d;
  logic [IDX_W-1:0] pend_i_q, pend_i_d;
  logic [127:0]     hold_q, hold_d;
  logic             err_d;
  logic             coll_wr, is_top, same;

  function automatic logic [127:0] put_word(input logic [127:0] base, input logic [1:0] w,
                                            input logic wd, input logic [63:0] d);
    logic [127:0] r;
    int wi;
    r  = base;
    wi = int'(w);
    r[32*wi +: 32] = d[31:0];
    if (wd && wi < 3) r[32*(wi+1) +: 32] = d[63:32];
    return r;
  endfunction

  always_comb begin
    coll_wr  = req_wr && (tgt.kind == K_WIDE || tgt.kind == K_SRAM);
    is_top   = (tgt.kind == K_WIDE) ? (wide ? tgt.word == 2'd2 : tgt.word == 2'd3)
                                    : (wide || tgt.word == 2'd1);
    same     = pend_v_q && pend_k_q == tgt.kind && pend_i_q == tgt.idx;
    pend_v_d = pend_v_q;
    pend_k_d = pend_k_q;
    pend_i_d = pend_i_q;
    hold_d   = hold_q;
    err_d    = seq_err;
    cmt_en   = 1'b0;
    cmt_data = '0;
    if (coll_wr) begin
      if (tgt.kind == K_SRAM && wide) begin
        cmt_en   = 1'b1;
        cmt_data = {64'd0, wdata};
      end else if (is_top) begin
        if (same) begin
          cmt_en   = 1'b1;
          cmt_data = put_word(hold_q, tgt.word, wide, wdata);
          pend_v_d = 1'b0;
          hold_d   = '0;
        end else begin
          err_d = 1'b1;
        end
      end else begin
        pend_v_d = 1'b1;
        pend_k_d = tgt.kind;
        pend_i_d = tgt.idx;
        hold_d   = put_word(same ? hold_q : 128'd0, tgt.word, wide, wdata);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_v_q <= 1'b0;
      pend_k_q <= K_NONE;
      pend_i_q <= '0;
      hold_q   <= '0;
      seq_err  <= 1'b0;
    end else if (coll_wr) begin
      pend_v_q <= pend_v_d;
      pend_k_q <= pend_k_d;
      pend_i_q <= pend_i_d;
      hold_q   <= hold_d;
      seq_err  <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      commit_stb  <= 1'b0;
      commit_sram <= 1'b0;
      commit_idx  <= '0;
      commit_data <= '0;
    end else begin
      commit_stb <= cmt_en;
      if (cmt_en) begin
        commit_sram <= (tgt.kind == K_SRAM);
        commit_idx  <= tgt.idx;
        commit_data <= cmt_data;
      end
    end
  end

  assert_db_keeps_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_wr && tgt.kind == K_DB) |=> ($stable(pend_v_q) && $stable(hold_q) && !commit_stb));
  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    seq_err |=> seq_err);
  assert_err_no_commit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(seq_err) |-> !commit_stb);
  assert_commit_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
    commit_stb |-> $past(req_wr));
endmodule

// File: rtl/wrc_bank.sv
module wrc_bank
  import wrc_pkg::*;
#(
  parameter int NUM_PAGES = 2,
  parameter int NUM_WIDE  = 4,
  parameter int NUM_SRAM  = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rd_req,
  input  logic         db_wr,
  input  logic         wide,
  input  tgt_t         tgt,
  input  logic [63:0]  wdata,
  input  logic         cmt_en,
  input  logic [127:0] cmt_data,
  output logic         rd_valid,
  output logic [63:0]  rd_data
);
  localparam int NW  = NUM_PAGES * NUM_WIDE;
  localparam int ND  = NUM_PAGES * NUM_DB;
  localparam int WIW = (NW > 1) ? $clog2(NW) : 1;
  localparam int SIW = (NUM_SRAM > 1) ? $clog2(NUM_SRAM) : 1;
  localparam int DIW = (ND > 1) ? $clog2(ND) : 1;

  logic [NW-1:0][127:0]     wide_v;
  logic [NUM_SRAM-1:0][63:0] sram_v;
  logic [ND-1:0][31:0]      db_v;
  logic [127:0]             shadow_q;
  logic [63:0]              rd_d;
  logic                     snap;

  for (genvar g = 0; g < NW; g++) begin : g_wide
    logic [127:0] val_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) val_q <= '0;
      else if (cmt_en && tgt.kind == K_WIDE && tgt.idx == IDX_W'(g)) val_q <= cmt_data;
    end
    assign wide_v[g] = val_q;
  end

  for (genvar g = 0; g < NUM_SRAM; g++) begin : g_sram
    logic [63:0] val_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) val_q <= '0;
      else if (cmt_en && tgt.kind == K_SRAM && tgt.idx == IDX_W'(g)) val_q <= cmt_data[63:0];
    end
    assign sram_v[g] = val_q;
  end

  for (genvar g = 0; g < ND; g++) begin : g_db
    logic [31:0] val_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) val_q <= '0;
      else if (db_wr && tgt.idx == IDX_W'(g)) val_q <= wdata[31:0];
    end
    assign db_v[g] = val_q;
  end

  always_comb begin
    logic [127:0] live;
    logic [63:0]  ent;
    live = wide_v[tgt.idx[WIW-1:0]];
    ent  = sram_v[tgt.idx[SIW-1:0]];
    snap = rd_req && tgt.kind == K_WIDE && tgt.word == 2'd0;
    rd_d = '0;
    case (tgt.kind)
      K_WIDE: begin
        case (tgt.word)
          2'd0:    rd_d = wide ? live[63:0] : {32'd0, live[31:0]};
          2'd1:    rd_d = {32'd0, shadow_q[63:32]};
          2'd2:    rd_d = wide ? shadow_q[127:64] : {32'd0, shadow_q[95:64]};
          default: rd_d = {32'd0, shadow_q[127:96]};
        endcase
      end
      K_SRAM:  rd_d = wide ? ent : (tgt.word[0] ? {32'd0, ent[63:32]} : {32'd0, ent[31:0]});
      K_DB:    rd_d = {32'd0, db_v[tgt.idx[DIW-1:0]]};
      default: rd_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
      shadow_q <= '0;
    end else begin
      rd_valid <= rd_req;
      if (rd_req) rd_data <= rd_d;
      if (snap) shadow_q <= wide_v[tgt.idx[WIW-1:0]];
    end
  end

  assert_rd_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(rd_req));
  assert_rd_narrow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !$past(wide)) |-> rd_data[63:32] == 32'd0);
  assert_shadow_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(snap) |-> $stable(shadow_q));
endmodule

// File: rtl/wide_reg_collector.sv
module wide_reg_collector
  import wrc_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int NUM_PAGES  = 2,
  parameter int NUM_WIDE   = 4,
  parameter int NUM_SRAM   = 8,
  parameter int PAGE_BYTES = 8192,
  parameter int SRAM_BASE  = 'h10000,
  parameter int DB_BASE    = 'h100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic              bus_wide,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [63:0]       bus_wdata,
  output logic              rd_valid,
  output logic [63:0]       rd_data,
  output logic              commit_stb,
  output logic              commit_sram,
  output logic [IDX_W-1:0]  commit_idx,
  output logic [127:0]      commit_data,
  output logic              seq_err
);
  tgt_t         tgt;
  logic         req_wr, rd_req, db_wr, cmt_en;
  logic [127:0] cmt_data;

  assign req_wr = bus_valid && bus_write;
  assign rd_req = bus_valid && !bus_write;
  assign db_wr  = req_wr && tgt.kind == K_DB;

  wrc_decode #(
    .ADDR_W(ADDR_W), .NUM_PAGES(NUM_PAGES), .NUM_WIDE(NUM_WIDE), .NUM_SRAM(NUM_SRAM),
    .PAGE_BYTES(PAGE_BYTES), .SRAM_BASE(SRAM_BASE), .DB_BASE(DB_BASE)
  ) u_decode (
    .addr(bus_addr), .wide(bus_wide), .tgt(tgt)
  );

  wrc_collector u_coll (
    .clk(clk), .rst_n(rst_n), .req_wr(req_wr), .wide(bus_wide), .tgt(tgt),
    .wdata(bus_wdata), .cmt_en(cmt_en), .cmt_data(cmt_data),
    .commit_stb(commit_stb), .commit_sram(commit_sram), .commit_idx(commit_idx),
    .commit_data(commit_data), .seq_err(seq_err)
  );

  wrc_bank #(
    .NUM_PAGES(NUM_PAGES), .NUM_WIDE(NUM_WIDE), .NUM_SRAM(NUM_SRAM)
  ) u_bank (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .db_wr(db_wr), .wide(bus_wide),
    .tgt(tgt), .wdata(bus_wdata), .cmt_en(cmt_en), .cmt_data(cmt_data),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );
endmodule

// File: tb/wide_reg_collector_tb_top.sv
`timescale 1ns/1ps
module wide_reg_collector_tb_top;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         bus_valid, bus_write, bus_wide;
  logic [19:0]  bus_addr;
  logic [63:0]  bus_wdata;
  logic         rd_valid, commit_stb, commit_sram, seq_err;
  logic [63:0]  rd_data;
  logic [5:0]   commit_idx;
  logic [127:0] commit_data;

  always #4 clk = ~clk;

  wide_reg_collector dut_i (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_wide(bus_wide), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .commit_stb(commit_stb),
    .commit_sram(commit_sram), .commit_idx(commit_idx), .commit_data(commit_data),
    .seq_err(seq_err)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  logic [127:0] m_wide [8];
  logic [63:0]  m_sram [8];
  logic [31:0]  m_db [6];
  logic [127:0] m_shadow, m_hold;
  bit           m_pv, m_err;
  int           m_pk, m_pi;

  function automatic logic [19:0] aw(int p, int n, int w);
    return 20'(p * 'h2000 + n * 16 + w * 4);
  endfunction
  function automatic logic [19:0] adb(int p, int k);
    return 20'(p * 'h2000 + 'h100 + k * 16);
  endfunction
  function automatic logic [19:0] asr(int i, int w);
    return 20'('h10000 + i * 8 + w * 4);
  endfunction

  // address map from R7 and R10: kind 0 none, 1 wide, 2 buffer, 3 doorbell
  function automatic void bdec(input logic [19:0] a, input bit wd,
                               output int k, output int ix, output int w);
    int p, o;
    k = 0; ix = 0; w = 0;
    if (a[1:0] != 2'b00 || (wd && a[2])) return;
    if (a >= 20'h10000 && a < 20'h10040) begin
      k = 2; ix = (int'(a) - 'h10000) / 8; w = int'(a[2]);
      return;
    end
    p = int'(a) / 'h2000; o = int'(a) % 'h2000;
    if (p >= 2) return;
    if (o < 64) begin
      k = 1; ix = p * 4 + o / 16; w = (o / 4) % 4;
    end else if (!wd && (o == 'h100 || o == 'h110 || o == 'h120)) begin
      k = 3; ix = p * 3 + (o - 'h100) / 16;
    end
  endfunction

  function automatic logic [127:0] place(logic [127:0] b, int w, bit wd, logic [63:0] d);
    logic [127:0] r = b;
    r[32*w +: 32] = d[31:0];
    if (wd) r[32*w+32 +: 32] = d[63:32];
    return r;
  endfunction

  task automatic chk(bit ok, string req, string what, logic [127:0] act, logic [127:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 8; i++) begin m_wide[i] = '0; m_sram[i] = '0; end
    for (int i = 0; i < 6; i++) m_db[i] = '0;
    m_shadow = '0; m_hold = '0; m_pv = 0; m_err = 0; m_pk = 0; m_pi = 0;
  endtask

  // one bus beat: called at a falling edge, checks at the next falling edge
  task automatic op(bit wr, bit wd, logic [19:0] a, logic [63:0] d, string tag);
    int k, ix, w;
    bit top, same, ec = 0, es = 0;
    int ei = 0;
    logic [127:0] ed = '0, nv;
    logic [63:0] er = '0;
    bdec(a, wd, k, ix, w);
    if (wr) begin
      if (k == 3) m_db[ix] = d[31:0];
      else if (k == 1 || k == 2) begin
        top  = (k == 1) ? (wd ? w == 2 : w == 3) : (wd || w == 1);
        same = m_pv && m_pk == k && m_pi == ix;
        if (k == 2 && wd) begin
          ec = 1; es = 1; ei = ix; ed = {64'd0, d}; m_sram[ix] = d;
        end else if (top) begin
          if (same) begin
            nv = place(m_hold, w, wd, d);
            ec = 1; es = (k == 2); ei = ix; ed = nv;
            if (k == 1) m_wide[ix] = nv; else m_sram[ix] = nv[63:0];
            m_pv = 0; m_hold = '0;
          end else m_err = 1;
        end else begin
          m_hold = place(same ? m_hold : 128'd0, w, wd, d);
          m_pv = 1; m_pk = k; m_pi = ix;
        end
      end
    end else begin
      if (k == 1) begin
        if (w == 0) begin
          m_shadow = m_wide[ix];
          er = wd ? m_shadow[63:0] : {32'd0, m_shadow[31:0]};
        end else er = wd ? m_shadow[32*w +: 64] : {32'd0, m_shadow[32*w +: 32]};
      end else if (k == 2) er = wd ? m_sram[ix] : {32'd0, m_sram[ix][32*w +: 32]};
      else if (k == 3) er = {32'd0, m_db[ix]};
    end
    bus_valid = 1'b1; bus_write = wr; bus_wide = wd; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0;
    chk(rd_valid == !wr, {tag, " R10"}, "rd_valid", 128'(rd_valid), 128'(!wr));
    if (!wr) chk(rd_data == er, tag, "rd_data", 128'(rd_data), 128'(er));
    chk(commit_stb == ec, {tag, " R11"}, "commit_stb", 128'(commit_stb), 128'(ec));
    if (ec) begin
      chk(commit_sram == es && int'(commit_idx) == ei, {tag, " R11"}, "commit target",
          128'({commit_sram, commit_idx}), 128'({es, 6'(ei)}));
      chk(commit_data == ed, {tag, " R11"}, "commit_data", commit_data, ed);
    end
    chk(seq_err == m_err, {tag, " R9"}, "seq_err", 128'(seq_err), 128'(m_err));
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED1234));
    bus_valid = 0; bus_write = 0; bus_wide = 0; bus_addr = '0; bus_wdata = '0;
    rst_n = 1'b0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!rd_valid && !commit_stb && !seq_err, "R1", "outputs after reset",
        128'({rd_valid, commit_stb, seq_err}), 128'd0);
    op(0, 1, aw(0, 1, 0), 0, "R1");
    op(0, 1, aw(0, 1, 2), 0, "R1");
    op(0, 1, asr(3, 0), 0, "R1");
    op(0, 0, adb(1, 2), 0, "R1");

    // R2 four narrow words, old value visible until the top word
    op(1, 0, aw(0, 1, 0), 64'h11111111, "R2");
    op(1, 0, aw(0, 1, 1), 64'h22222222, "R2");
    op(1, 0, aw(0, 1, 2), 64'h33333333, "R2");
    op(0, 0, aw(0, 1, 0), 0, "R2");
    op(1, 0, aw(0, 1, 3), 64'h44444444, "R2");
    op(0, 0, aw(0, 1, 0), 0, "R2");
    op(0, 0, aw(0, 1, 3), 0, "R2");

    // R3 two wide beats, then mixed sizes
    op(1, 1, aw(1, 2, 0), 64'hA1A2A3A4_B1B2B3B4, "R3");
    op(1, 1, aw(1, 2, 2), 64'hC1C2C3C4_D1D2D3D4, "R3");
    op(0, 1, aw(1, 2, 0), 0, "R3");
    op(0, 1, aw(1, 2, 2), 0, "R3");
    op(1, 1, aw(0, 3, 0), 64'h01234567_89ABCDEF, "R3");
    op(1, 0, aw(0, 3, 2), 64'h5555AAAA, "R3");
    op(1, 0, aw(0, 3, 3), 64'h6666BBBB, "R3");

    // R4 buffer entries, and a full-width entry write inside a collection
    op(1, 0, asr(2, 0), 64'hDEAD0001, "R4");
    op(1, 0, asr(2, 1), 64'hBEEF0002, "R4");
    op(0, 1, asr(2, 0), 0, "R4");
    op(1, 0, aw(1, 0, 0), 64'h70000000, "R4");
    op(1, 1, asr(7, 0), 64'hFEDCBA98_76543210, "R4");
    op(1, 1, aw(1, 0, 2), 64'h72000000_71000000, "R4");
    op(0, 0, asr(7, 1), 0, "R4");

    // R5 shadow survives a later update
    op(0, 0, aw(0, 1, 0), 0, "R5");
    op(1, 1, aw(0, 1, 0), 64'h99999999_88888888, "R5");
    op(1, 1, aw(0, 1, 2), 64'h77777777_66666666, "R5");
    op(0, 1, aw(0, 1, 2), 0, "R5");
    op(0, 0, aw(0, 1, 1), 0, "R5");
    op(0, 0, aw(0, 1, 0), 0, "R5");

    // R6 doorbell in the middle of a collection
    op(1, 0, aw(1, 3, 0), 64'hCAFE0000, "R6");
    op(1, 0, aw(1, 3, 1), 64'hCAFE0001, "R6");
    op(1, 0, adb(1, 1), 64'h00000123, "R6");
    op(0, 0, adb(1, 1), 0, "R6");
    op(1, 0, aw(1, 3, 2), 64'hCAFE0002, "R6");
    op(1, 0, adb(0, 0), 64'h00000456, "R6");
    op(1, 0, aw(1, 3, 3), 64'hCAFE0003, "R6");
    op(0, 0, adb(0, 0), 0, "R6");

    // R7 page and index spacing
    op(1, 1, aw(1, 1, 0), 64'h1, "R7");
    op(1, 1, aw(1, 1, 2), 64'h2, "R7");
    op(0, 1, aw(0, 1, 0), 0, "R7");
    op(0, 0, adb(1, 2), 0, "R7");

    // R8 restart on a lower word to a different register
    op(1, 0, aw(0, 0, 0), 64'hAAAA0000, "R8");
    op(1, 0, aw(0, 2, 1), 64'hBBBB0001, "R8");
    op(1, 1, aw(0, 2, 2), 64'hBBBB0003_BBBB0002, "R8");

    // R9 top word without matching pending register
    op(1, 0, aw(0, 0, 1), 64'hEEEE0001, "R9");
    op(1, 0, aw(0, 1, 3), 64'hEEEE0003, "R9");
    op(0, 0, aw(0, 1, 0), 0, "R9");
    op(1, 0, aw(0, 0, 3), 64'hEEEE0004, "R9");

    // R10 unmapped, misaligned and odd-word wide accesses
    op(0, 0, 20'h01F00, 0, "R10");
    op(0, 1, aw(0, 3, 1), 0, "R10");
    op(1, 0, 20'h00012, 64'hFFFFFFFF, "R10");
    op(1, 1, adb(0, 1), 64'hFFFFFFFF_FFFFFFFF, "R10");
    op(0, 0, adb(0, 1), 0, "R10");
    op(0, 0, aw(0, 0, 0), 0, "R10");

    // constrained random mix of all request classes
    for (int i = 0; i < 4000; i++) begin
      int r, p, n, w;
      bit wr, wd;
      logic [19:0] a;
      logic [63:0] d;
      r  = int'($urandom % 10);
      p  = int'($urandom % 2);
      n  = int'($urandom % 2);
      w  = int'($urandom % 4);
      wr = ($urandom % 3) != 0;
      wd = ($urandom % 2) != 0;
      d  = {$urandom, $urandom};
      if (r < 6) a = aw(p, n, w);
      else if (r < 8) a = asr(n + 2 * p, w % 2);
      else if (r < 9) a = adb(p, w % 3);
      else a = 20'(($urandom % 'h4000) & 32'hFFFC);
      op(wr, wd, a, d, "R2 R6 rand");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule